// File: doc/BRIEF.md
# Saturating CPU-Cycle Interrupt Counter

This block is a 16-bit up-counter that advances once per CPU bus cycle and requests an interrupt when it reaches all-ones. Every cycle-end pulse moves the counter up by one, unless its value is already 0xFFFF. At 0xFFFF it stays put. The interrupt output is active-low. It is a level that holds for as long as the count is 0xFFFF and interrupts are enabled. It is not a pulse taken on overflow, and the counter never wraps.

The CPU controls the block through three write-only registers, picked by the low four bits of the address. The write strobe is assumed to be already qualified by the upper write window.

- A write of any value to index 0xD clears the count and disables interrupts, which also withdraws a pending request.
- A write to index 0xE replaces the low byte of the count.
- A write to index 0xF replaces the high byte and enables interrupts.

Software arms the timer by loading the two bytes with the low byte first. The count runs up to all-ones, and the handler acknowledges with a write to index 0xD.

Top module: `cyc_irq_timer`

## Requirements
- R1: While rst_ni is low and after its release, the count is 0x0000, interrupts are disabled and irq_no is 1.
- R2: With no write in a cycle, a cycle_end_i pulse increments the count by exactly one when the count is not 0xFFFF.
- R3: In a cycle with neither a write nor cycle_end_i, the count and the enable hold their values.
- R4: At 0xFFFF the count saturates: further cycle_end_i pulses leave it at 0xFFFF and it never wraps to 0.
- R5: irq_no is 0 exactly when the enable is set and the count is 0xFFFF. It is a level that persists with no further input.
- R6: A write to index 0xD (reg_idx_i = 4'hD), with any data, sets the count to 0x0000 and clears the enable, releasing irq_no to 1.
- R7: A write to index 0xE loads wr_data_i into count bits 7:0 and leaves bits 15:8 and the enable unchanged.
- R8: A write to index 0xF loads wr_data_i into count bits 15:8, leaves bits 7:0 unchanged and sets the enable.
- R9: When a write and a cycle_end_i pulse occur in the same cycle, the write takes effect and the increment is discarded.
- R10: Writes to indices 0x0 to 0xC change neither the count nor the enable.
- R11: Loading 0xFFFF with the enable set drives irq_no to 0 in the cycle after the write, with no cycle_end_i pulse needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | CPU write strobe, one cycle per write, pre-qualified by the write window |
| reg_idx_i | input | 4 | Register index taken from the low address bits |
| wr_data_i | input | 8 | Write data |
| cycle_end_i | input | 1 | One-cycle pulse marking the end of a CPU bus cycle |
| irq_no | output | 1 | Active-low interrupt request level |

## Verification
The assertions take the inputs to be synchronous to clk_i and free of X. They also take each asserted wr_en_i to be one complete write, with reg_idx_i and wr_data_i valid in that same cycle. The bench changes every input only on the falling clock edge and holds the write strobe and cycle_end_i for one cycle at a time. Same-cycle collisions between a write and cycle_end_i are created on purpose. The count has no output, so the bench infers it at the port: it enables interrupts with the high byte at 0xFF and counts the pulses needed before irq_no falls.

// File: rtl/cyc_irq_pkg.sv
package cyc_irq_pkg;
  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_CLR,
    CMD_LO,
    CMD_HI
  } cmd_e;
endpackage

// File: rtl/cyc_irq_decode.sv
module cyc_irq_decode
  import cyc_irq_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int IDX_CLR = 13,
  parameter int IDX_LO  = 14,
  parameter int IDX_HI  = 15
) (
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] reg_idx_i,
  output cmd_e             cmd_o
);
  always_comb begin
    cmd_o = CMD_NONE;
    if (wr_en_i) begin
      if (reg_idx_i == IDX_W'(IDX_CLR))     cmd_o = CMD_CLR;
      else if (reg_idx_i == IDX_W'(IDX_LO)) cmd_o = CMD_LO;
      else if (reg_idx_i == IDX_W'(IDX_HI)) cmd_o = CMD_HI;
    end
  end
endmodule

// File: rtl/cyc_irq_count.sv
module cyc_irq_count
  import cyc_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              cycle_end_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              at_max_o
);
  localparam int LO_W = DATA_W;
  localparam int HI_W = CNT_W - DATA_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign at_max_o = &cnt_q;
  assign cnt_o    = cnt_q;

  // writes win over the cycle-end increment
  always_comb begin
    cnt_d = cnt_q;
    unique case (cmd_i)
      CMD_CLR: cnt_d = '0;
      CMD_LO:  cnt_d[LO_W-1:0] = data_i;
      CMD_HI:  cnt_d[CNT_W-1:LO_W] = HI_W'(data_i);
      default: if (cycle_end_i && !at_max_o) cnt_d = cnt_q + 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cyc_irq_flag.sv
module cyc_irq_flag
  import cyc_irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cmd_e cmd_i,
  input  logic at_max_i,
  output logic en_o,
  output logic irq_no
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                en_q <= 1'b0;
    else if (cmd_i == CMD_CLR)  en_q <= 1'b0;
    else if (cmd_i == CMD_HI)   en_q <= 1'b1;
  end

  assign en_o   = en_q;
  assign irq_no = ~(en_q & at_max_i);
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
  import cyc_irq_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int DATA_W  = 8,
  parameter int IDX_CLR = 13,
  parameter int IDX_LO  = 14,
  parameter int IDX_HI  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              cycle_end_i,
  output logic              irq_no
);
  localparam int CNT_W = 2 * DATA_W;

  cmd_e             cmd;
  logic [CNT_W-1:0] cnt;
  logic             at_max;
  logic             irq_en;

  cyc_irq_decode #(
    .IDX_W(IDX_W), .IDX_CLR(IDX_CLR), .IDX_LO(IDX_LO), .IDX_HI(IDX_HI)
  ) u_decode (
    .wr_en_i  (wr_en_i),
    .reg_idx_i(reg_idx_i),
    .cmd_o    (cmd)
  );

  cyc_irq_count #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .data_i     (wr_data_i),
    .cycle_end_i(cycle_end_i),
    .cnt_o      (cnt),
    .at_max_o   (at_max)
  );

  cyc_irq_flag u_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_i   (cmd),
    .at_max_i(at_max),
    .en_o    (irq_en),
    .irq_no  (irq_no)
  );
endmodule

// File: rtl/cyc_irq_timer_chk.sv
module cyc_irq_timer_chk #(
  parameter int IDX_W   = 4,
  parameter int DATA_W  = 8,
  parameter int IDX_CLR = 13,
  parameter int IDX_LO  = 14,
  parameter int IDX_HI  = 15
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [IDX_W-1:0]    reg_idx_i,
  input logic [DATA_W-1:0]   wr_data_i,
  input logic                cycle_end_i,
  input logic [2*DATA_W-1:0] cnt,
  input logic                irq_en,
  input logic                irq_no
);
  localparam int CNT_W = 2 * DATA_W;
  localparam logic [CNT_W-1:0] MAX = '1;

  logic wr_clr, wr_lo, wr_hi, wr_other;
  assign wr_clr   = wr_en_i && reg_idx_i == IDX_W'(IDX_CLR);
  assign wr_lo    = wr_en_i && reg_idx_i == IDX_W'(IDX_LO);
  assign wr_hi    = wr_en_i && reg_idx_i == IDX_W'(IDX_HI);
  assign wr_other = wr_en_i && !wr_clr && !wr_lo && !wr_hi;

  always_comb begin
    if (!rst_ni) assert_reset_R1: assert (cnt == '0 && !irq_en && irq_no);
  end

  assert_incr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && cycle_end_i && cnt != MAX) |=> cnt == $past(cnt) + 1'b1);

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !cycle_end_i) |=> ($stable(cnt) && $stable(irq_en)));

  assert_no_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == MAX && !wr_en_i) |=> cnt == MAX);

  assert_irq_level_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_no == !(irq_en && cnt == MAX));

  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> (cnt == '0 && !irq_en && irq_no));

  assert_load_lo_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo |=> (cnt[DATA_W-1:0] == $past(wr_data_i) &&
               cnt[CNT_W-1:DATA_W] == $past(cnt[CNT_W-1:DATA_W]) && $stable(irq_en)));

  assert_load_hi_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi |=> (cnt[CNT_W-1:DATA_W] == $past(wr_data_i) &&
               cnt[DATA_W-1:0] == $past(cnt[DATA_W-1:0]) && irq_en));

  assert_ignore_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_other && !cycle_end_i) |=> ($stable(cnt) && $stable(irq_en)));
endmodule

bind cyc_irq_timer cyc_irq_timer_chk #(
  .IDX_W(IDX_W), .DATA_W(DATA_W), .IDX_CLR(IDX_CLR), .IDX_LO(IDX_LO), .IDX_HI(IDX_HI)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .reg_idx_i  (reg_idx_i),
  .wr_data_i  (wr_data_i),
  .cycle_end_i(cycle_end_i),
  .cnt        (cnt),
  .irq_en     (irq_en),
  .irq_no     (irq_no)
);

// File: tb/cyc_irq_timer_bench.sv
module cyc_irq_timer_bench;
  localparam logic [3:0] I_CLR = 4'hD, I_LO = 4'hE, I_HI = 4'hF;
  // {low byte loaded, expected pulses until irq with high byte 0xFF}
  localparam int NVEC = 6;
  localparam logic [15:0] VEC [NVEC] = '{
    {8'h00, 8'd255}, {8'h01, 8'd254}, {8'h7F, 8'd128},
    {8'h80, 8'd127}, {8'hFE, 8'd1},   {8'hFF, 8'd0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] reg_idx = '0;
  logic [7:0] wr_data = '0;
  logic       cycle_end = 1'b0;
  logic       irq_n;
  int         checks = 0;
  int         fails = 0;

  always #5ns clk = ~clk;

  cyc_irq_timer u_cyc_irq_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .reg_idx_i(reg_idx),
    .wr_data_i(wr_data), .cycle_end_i(cycle_end), .irq_no(irq_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [7:0] d, input logic ce);
    @(negedge clk);
    wr_en = 1'b1; reg_idx = idx; wr_data = d; cycle_end = ce;
    @(negedge clk);
    wr_en = 1'b0; cycle_end = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk); cycle_end = 1'b1;
    @(negedge clk); cycle_end = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic to_irq(output int n);
    n = 0;
    while (irq_n === 1'b1 && n < 300) begin
      pulse();
      n++;
    end
  endtask

  initial begin
    int n;
    idle(3);
    chk("R1 irq high in reset", int'(irq_n), 1);
    rst_n = 1'b1;
    idle(2);
    chk("R1 irq high after reset", int'(irq_n), 1);
    wr(I_HI, 8'hFF, 1'b0);
    to_irq(n);
    chk("R1 low byte zero after reset", n, 255);

    for (int i = 0; i < NVEC; i++) begin
      wr(I_CLR, 8'h00, 1'b0);
      wr(I_LO, VEC[i][15:8], 1'b0);
      wr(I_HI, 8'hFF, 1'b0);
      to_irq(n);
      chk("R2 R7 R11 pulses to irq", n, int'(VEC[i][7:0]));
    end

    // last vector left the count at 0xFFFF with irq asserted
    repeat (5) pulse();
    chk("R4 saturate, no wrap", int'(irq_n), 0);
    idle(8);
    chk("R5 level holds", int'(irq_n), 0);
    wr(I_CLR, 8'hA5, 1'b0);
    chk("R6 clear releases irq", int'(irq_n), 1);
    wr(I_HI, 8'hFF, 1'b0);
    to_irq(n);
    chk("R6 count cleared", n, 255);

    wr(I_CLR, 8'h00, 1'b0);
    wr(I_LO, 8'hFD, 1'b0);
    wr(I_HI, 8'hFF, 1'b0);
    to_irq(n);
    chk("R8 low kept, enable set", n, 2);
    wr(I_CLR, 8'h00, 1'b0);
    wr(I_HI, 8'hFE, 1'b0);
    wr(I_LO, 8'hFF, 1'b0);
    to_irq(n);
    chk("R8 high byte 0xFE loaded", n, 256);

    wr(I_CLR, 8'h00, 1'b1);
    wr(I_HI, 8'hFF, 1'b0);
    to_irq(n);
    chk("R9 clear beats increment", n, 255);
    wr(I_CLR, 8'h00, 1'b0);
    wr(I_HI, 8'hFF, 1'b0);
    wr(I_LO, 8'h10, 1'b1);
    to_irq(n);
    chk("R9 low load beats increment", n, 239);

    wr(I_CLR, 8'h00, 1'b0);
    wr(I_LO, 8'hFE, 1'b0);
    wr(I_HI, 8'hFF, 1'b0);
    idle(10);
    chk("R3 hold without pulses", int'(irq_n), 1);
    to_irq(n);
    chk("R3 count held", n, 1);

    wr(I_CLR, 8'h00, 1'b0);
    wr(I_HI, 8'hFF, 1'b0);
    wr(I_LO, 8'h40, 1'b0);
    wr(4'h3, 8'hFF, 1'b0);
    wr(4'hC, 8'h00, 1'b0);
    wr(4'h0, 8'h12, 1'b0);
    to_irq(n);
    chk("R10 other indices ignored", n, 191);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule